// File: doc/BRIEF.md
# Core Module System Control Register File

This block is the small control register file that sits beside a processor core module. It is attached to a plain 32-bit bus with separate read and write strobes and a byte offset. It answers reads one clock after the strobe and applies writes on the strobe edge. It holds the clock settings, a board-control word, two flag words with separate set and clear addresses, memory configuration words and a one-bit local interrupt source with its own IRQ and FIQ masks. A read-only window at the top of the map returns the bytes of a memory-module presence table, one byte per word.

The clock-setting words are protected by a 16-bit key held in a lock word, so a stray write cannot retune the core. The control word drives a status LED and the boot-remap select. It also carries a trigger bit that is never stored: writing it produces a single-cycle reset request. The memory size is fixed at elaboration through a parameter. That parameter sets both the size code in the SDRAM word and the size byte in the presence table. Any access to an index this block does not implement reads as zero, changes nothing and pulses an error flag.

Top module: `core_ctl_regs`

## Requirements
- R1: Register index is offset/4 (offset bits 1:0 ignored). Index 0 reads 0x411A3001, index 1 reads 0, index 4 reads 0x00100000, and indices 32 to 35 read 0 and ignore writes.
- R2: A write to index 5 stores wdata[15:0] in the lock word. A read of index 5 returns 0x0001A05F when the stored value is 0xA05F, and the stored value zero-extended otherwise.
- R3: A write to index 2 (oscillator) or index 7 (auxiliary oscillator) stores all 32 bits only while the lock word equals 0xA05F, and is ignored otherwise.
- R4: A write to index 3 stores wdata[0] and wdata[2]. A read of index 3 returns them in bits 0 and 2, with all other bits zero. Output led follows bit 0 and output remap follows bit 2, from the edge of the write.
- R5: A write to index 3 with wdata[3] set drives rst_req high for exactly the one cycle after the write edge. rst_req is low at every other time.
- R6: Index 12 ORs wdata into the flags word and index 13 clears the bits set in wdata; index 12 reads it. Indices 14, 15 and 14 do the same for the non-volatile flags word.
- R7: Index 8 (SDRAM) and index 9 (init) are freely writable 32-bit words. Their reset values are 0x00011122 ORed with the size code (0x10 for at least 256 MB, 0x0C for at least 128 MB, 0x08 for at least 64 MB, 0x04 for at least 32 MB, else 0) and 0x00000112.
- R8: Offsets 0x100 to 0x17C return, in bits 7:0, byte (offset-0x100)/4 of the 32-byte presence table. Byte 31 holds the size byte (64, 32, 16, 4 or 2 for the same size steps as R7). Offsets 0x180 to 0x1FF read 0. The whole window is read-only.
- R9: Indices 18/19 set/clear IRQ mask bits and 26/27 set/clear FIQ mask bits. Index 18 and index 26 read the masks. Indices 17 and 25 read the raw level, and indices 16 and 24 read the raw level ANDed with the respective mask.
- R10: Writing index 20 with bit 0 set raises the software interrupt level, and writing index 21 with bit 0 set lowers it. Other bits are ignored. Index 20 reads the level in bit 0. cm_int is high while the level is set and bit 0 of either mask is set.
- R11: A read of an index not listed for reading, or a write to an index not listed for writing, returns 0 and changes no state. It also drives err high for exactly the cycle after the access.
- R12: A read and a write in the same cycle return the value held before that write. The written value is visible to the next read.
- R13: After reset the oscillator reads 0x01000048, the auxiliary oscillator 0x0007FEFF, and the lock, control, flags, masks and interrupt level read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en, held until the next read |
| led | output | 1 | Status LED (control bit 0) |
| remap | output | 1 | Remap select (control bit 2) |
| rst_req | output | 1 | One-cycle system reset request |
| cm_int | output | 1 | Local interrupt flag |
| err | output | 1 | One-cycle flag for an access to an unimplemented index |

## Verification
The read path and the write path can hit the same register in one cycle. The bench provokes this by raising both strobes on the SDRAM word with a new value. It then expects the old value on that read and the new value on a following plain read. A second overlap arises when a reset-trigger write also changes the stored LED and remap bits: the bench expects rst_req and the new outputs in the same cycle, and rst_req low one cycle later. Around these cases, full sweeps over every index before and after a burst of illegal writes compare each readback and each err pulse against a model kept in the bench.

// File: rtl/core_ctl_regs.sv
module core_ctl_regs #(
  parameter int MEM_MB = 128,
  parameter int AW     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          led,
  output logic          remap,
  output logic          rst_req,
  output logic          cm_int,
  output logic          err
);
  localparam int IW = AW - 2;
  localparam logic [15:0] KEY = 16'hA05F;
  localparam logic [7:0] SIZE_CODE = (MEM_MB >= 256) ? 8'h10 : (MEM_MB >= 128) ? 8'h0C :
                                     (MEM_MB >= 64)  ? 8'h08 : (MEM_MB >= 32)  ? 8'h04 : 8'h00;
  localparam logic [7:0] SIZE_BYTE = (MEM_MB >= 256) ? 8'd64 : (MEM_MB >= 128) ? 8'd32 :
                                     (MEM_MB >= 64)  ? 8'd16 : (MEM_MB >= 32)  ? 8'd4  : 8'd2;
  localparam logic [31:0] SDR_RST = 32'h00011122 | {24'h0, SIZE_CODE};

  localparam logic [IW-1:0] I_ID = IW'(0),   I_PROC = IW'(1),  I_OSC = IW'(2),   I_CTRL = IW'(3);
  localparam logic [IW-1:0] I_STAT = IW'(4), I_LOCK = IW'(5),  I_AUX = IW'(7),   I_SDR = IW'(8);
  localparam logic [IW-1:0] I_INIT = IW'(9), I_FLG = IW'(12),  I_FLGC = IW'(13), I_NVF = IW'(14);
  localparam logic [IW-1:0] I_NVFC = IW'(15), I_IST = IW'(16), I_IRAW = IW'(17), I_IEN = IW'(18);
  localparam logic [IW-1:0] I_IENC = IW'(19), I_SWS = IW'(20), I_SWC = IW'(21),  I_FST = IW'(24);
  localparam logic [IW-1:0] I_FRAW = IW'(25), I_FEN = IW'(26), I_FENC = IW'(27);

  logic [IW-1:0] idx;
  logic [31:0] osc_q, aux_q, sdr_q, init_q, flg_q, nvf_q, ien_q, fen_q;
  logic [15:0] lock_q;
  logic        soft_q, unlocked, in_volt, in_spd;
  logic        rd_ok, wr_ok;
  logic [31:0] rd_val;

  assign idx      = addr[AW-1:2];
  assign unlocked = (lock_q == KEY);
  assign in_volt  = (idx >= IW'(32)) && (idx <= IW'(35));
  assign in_spd   = (idx >= IW'(64)) && (idx <= IW'(127));
  assign cm_int   = soft_q & (ien_q[0] | fen_q[0]);

  function automatic logic [7:0] spd_byte(input logic [4:0] i);
    case (i)
      5'd0:  return 8'd128;
      5'd1:  return 8'd8;
      5'd2:  return 8'd4;
      5'd3:  return 8'd11;
      5'd4:  return 8'd9;
      5'd5:  return 8'd1;
      5'd6:  return 8'd64;
      5'd8:  return 8'd2;
      5'd9:  return 8'hA0;
      5'd10: return 8'hA0;
      5'd13: return 8'd8;
      5'd15: return 8'd1;
      5'd16: return 8'h0E;
      5'd17: return 8'd4;
      5'd18: return 8'h1C;
      5'd19: return 8'd1;
      5'd20: return 8'd2;
      5'd21: return 8'h20;
      5'd22: return 8'hC0;
      5'd27: return 8'h30;
      5'd28: return 8'h28;
      5'd29: return 8'h30;
      5'd30: return 8'h28;
      5'd31: return SIZE_BYTE;
      default: return 8'd0;
    endcase
  endfunction

  always_comb begin
    rd_ok  = 1'b1;
    rd_val = 32'h0;
    if (in_volt) begin
      rd_val = 32'h0;
    end else if (in_spd) begin
      rd_val = idx[5] ? 32'h0 : {24'h0, spd_byte(idx[4:0])};
    end else begin
      case (idx)
        I_ID:   rd_val = 32'h411A3001;
        I_PROC: rd_val = 32'h0;
        I_OSC:  rd_val = osc_q;
        I_CTRL: rd_val = {29'h0, remap, 1'b0, led};
        I_STAT: rd_val = 32'h00100000;
        I_LOCK: rd_val = unlocked ? 32'h0001A05F : {16'h0, lock_q};
        I_AUX:  rd_val = aux_q;
        I_SDR:  rd_val = sdr_q;
        I_INIT: rd_val = init_q;
        I_FLG:  rd_val = flg_q;
        I_NVF:  rd_val = nvf_q;
        I_IST:  rd_val = {31'h0, soft_q} & ien_q;
        I_IRAW: rd_val = {31'h0, soft_q};
        I_IEN:  rd_val = ien_q;
        I_SWS:  rd_val = {31'h0, soft_q};
        I_FST:  rd_val = {31'h0, soft_q} & fen_q;
        I_FRAW: rd_val = {31'h0, soft_q};
        I_FEN:  rd_val = fen_q;
        default: rd_ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    wr_ok = 1'b1;
    if (!in_volt) begin
      case (idx)
        I_OSC, I_CTRL, I_LOCK, I_AUX, I_SDR, I_INIT, I_FLG, I_FLGC, I_NVF, I_NVFC,
        I_IEN, I_IENC, I_SWS, I_SWC, I_FEN, I_FENC: wr_ok = 1'b1;
        default: wr_ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= 32'h0;
      err     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_ok ? rd_val : 32'h0;
      err     <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
      rst_req <= wr_en && (idx == I_CTRL) && wdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q  <= 32'h01000048;
      aux_q  <= 32'h0007FEFF;
      sdr_q  <= SDR_RST;
      init_q <= 32'h00000112;
      lock_q <= 16'h0;
      led    <= 1'b0;
      remap  <= 1'b0;
      flg_q  <= 32'h0;
      nvf_q  <= 32'h0;
      ien_q  <= 32'h0;
      fen_q  <= 32'h0;
      soft_q <= 1'b0;
    end else if (wr_en && !in_volt) begin
      case (idx)
        I_OSC:  if (unlocked) osc_q <= wdata;
        I_AUX:  if (unlocked) aux_q <= wdata;
        I_CTRL: begin led <= wdata[0]; remap <= wdata[2]; end
        I_LOCK: lock_q <= wdata[15:0];
        I_SDR:  sdr_q  <= wdata;
        I_INIT: init_q <= wdata;
        I_FLG:  flg_q  <= flg_q | wdata;
        I_FLGC: flg_q  <= flg_q & ~wdata;
        I_NVF:  nvf_q  <= nvf_q | wdata;
        I_NVFC: nvf_q  <= nvf_q & ~wdata;
        I_IEN:  ien_q  <= ien_q | wdata;
        I_IENC: ien_q  <= ien_q & ~wdata;
        I_FEN:  fen_q  <= fen_q | wdata;
        I_FENC: fen_q  <= fen_q & ~wdata;
        I_SWS:  if (wdata[0]) soft_q <= 1'b1;
        I_SWC:  if (wdata[0]) soft_q <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/core_ctl_regs_chk.sv
module core_ctl_regs_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          rst_req,
  input logic          err,
  input logic          led,
  input logic          remap,
  input logic [31:0]   osc_q,
  input logic [15:0]   lock_q
);
  logic ctrl_hit;
  assign ctrl_hit = wr_en && (addr[AW-1:2] == (AW-2)'(3));

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ctrl_hit && wdata[3])); // R5
  AST_RST_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_hit && wdata[3]) |-> rst_req); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_en || wr_en)); // R11
  AST_OSC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(osc_q) |-> $past(wr_en && lock_q == 16'hA05F)); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(led) || !$stable(remap)) |-> $past(ctrl_hit)); // R4
endmodule

bind core_ctl_regs core_ctl_regs_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_core_ctl_regs.sv
`timescale 1ns/1ps
module sim_core_ctl_regs;
  localparam int AW = 12;
  localparam int NIDX = 131;

  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic led, remap, rst_req, cm_int, err;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  core_ctl_regs #(.MEM_MB(128), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .led(led), .remap(remap), .rst_req(rst_req), .cm_int(cm_int), .err(err));

  logic [31:0] m_osc, m_aux, m_sdr, m_init, m_flg, m_nvf, m_ien, m_fen;
  logic [15:0] m_lock;
  logic m_led, m_rmp, m_soft;
  logic [31:0] g_rd;
  logic g_err, g_rst;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_sdr = 32'h0001112E; m_init = 32'h112;
    m_flg = 0; m_nvf = 0; m_ien = 0; m_fen = 0; m_lock = 0; m_led = 0; m_rmp = 0; m_soft = 0;
  endtask

  function automatic bit rd_valid(input int i);
    return (i <= 5) || (i >= 7 && i <= 9) || i == 12 || i == 14 || (i >= 16 && i <= 18) ||
           i == 20 || (i >= 24 && i <= 26) || (i >= 32 && i <= 35) || (i >= 64 && i <= 127);
  endfunction

  function automatic bit wr_valid(input int i);
    return (i == 2 || i == 3 || i == 5) || (i >= 7 && i <= 9) || (i >= 12 && i <= 15) ||
           (i >= 18 && i <= 21) || i == 26 || i == 27 || (i >= 32 && i <= 35);
  endfunction

  function automatic logic [7:0] exp_spd(input int j);
    logic [7:0] t [32] = '{8'd128, 8'd8, 8'd4, 8'd11, 8'd9, 8'd1, 8'd64, 8'd0, 8'd2, 8'hA0, 8'hA0,
      8'd0, 8'd0, 8'd8, 8'd0, 8'd1, 8'h0E, 8'd4, 8'h1C, 8'd1, 8'd2, 8'h20, 8'hC0, 8'd0, 8'd0,
      8'd0, 8'd0, 8'h30, 8'h28, 8'h30, 8'h28, 8'd32};
    return t[j];
  endfunction

  function automatic logic [31:0] exp_rd(input int i);
    if (!rd_valid(i)) return 0;
    if (i >= 64) return (i < 96) ? {24'h0, exp_spd(i - 64)} : 32'h0;
    case (i)
      0: return 32'h411A3001;
      2: return m_osc;
      3: return {29'h0, m_rmp, 1'b0, m_led};
      4: return 32'h00100000;
      5: return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'h0, m_lock};
      7: return m_aux;
      8: return m_sdr;
      9: return m_init;
      12: return m_flg;
      14: return m_nvf;
      16: return {31'h0, m_soft} & m_ien;
      17, 25, 20: return {31'h0, m_soft};
      18: return m_ien;
      24: return {31'h0, m_soft} & m_fen;
      26: return m_fen;
      default: return 0;
    endcase
  endfunction

  task automatic model_wr(input int i, input logic [31:0] d);
    case (i)
      2: if (m_lock == 16'hA05F) m_osc = d;
      7: if (m_lock == 16'hA05F) m_aux = d;
      3: begin m_led = d[0]; m_rmp = d[2]; end
      5: m_lock = d[15:0];
      8: m_sdr = d;
      9: m_init = d;
      12: m_flg |= d;
      13: m_flg &= ~d;
      14: m_nvf |= d;
      15: m_nvf &= ~d;
      18: m_ien |= d;
      19: m_ien &= ~d;
      26: m_fen |= d;
      27: m_fen &= ~d;
      20: if (d[0]) m_soft = 1;
      21: if (d[0]) m_soft = 0;
      default: ;
    endcase
  endtask

  task automatic acc(input bit r, input bit w, input int i, input logic [31:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = AW'(i << 2); wdata = d;
    @(negedge clk);
    g_rd = rdata; g_err = err; g_rst = rst_req;
    rd_en = 0; wr_en = 0;
    if (w) model_wr(i, d);
  endtask

  function automatic string tag_of(input int i);
    if (i >= 64 && i <= 127) return "R8";
    if (!rd_valid(i)) return "R11";
    if (i == 2 || i == 7) return "R13";
    if (i == 8 || i == 9) return "R7";
    if (i == 5) return "R2";
    if (i == 3) return "R4";
    if (i == 12 || i == 14) return "R6";
    if (i >= 16 && i <= 26) return "R9";
    return "R1";
  endfunction

  task automatic rd_chk(input int i, input string tag);
    acc(1, 0, i, 0);
    chk(tag, g_rd, exp_rd(i));
  endtask

  task automatic sweep();
    for (int i = 0; i < NIDX; i++) begin
      acc(1, 0, i, 0);
      chk(tag_of(i), g_rd, exp_rd(i));
      chk("R11 err", {31'h0, g_err}, {31'h0, !rd_valid(i)});
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 led reset", {31'h0, led}, 0);
    chk("R4 remap reset", {31'h0, remap}, 0);
    chk("R5 rst_req reset", {31'h0, rst_req}, 0);
    chk("R10 cm_int reset", {31'h0, cm_int}, 0);
    chk("R11 err reset", {31'h0, err}, 0);
    sweep();

    acc(0, 1, 2, 32'h12345678); rd_chk(2, "R3 locked osc");
    acc(0, 1, 7, 32'hCAFEF00D); rd_chk(7, "R3 locked aux");
    acc(0, 1, 5, 32'hFFFFA05F); rd_chk(5, "R2 unlocked read");
    acc(0, 1, 2, 32'h12345678); rd_chk(2, "R3 unlocked osc");
    acc(0, 1, 7, 32'hCAFEF00D); rd_chk(7, "R3 unlocked aux");
    acc(0, 1, 5, 32'h0000A05E); rd_chk(5, "R2 other key");
    acc(0, 1, 2, 32'h0); rd_chk(2, "R3 relocked osc");

    acc(0, 1, 3, 32'hFFFFFFF7);
    chk("R4 led", {31'h0, led}, 1);
    chk("R4 remap", {31'h0, remap}, 1);
    chk("R5 no trigger", {31'h0, g_rst}, 0);
    rd_chk(3, "R4 ctrl read");
    acc(0, 1, 3, 32'h0000000D);
    chk("R5 pulse", {31'h0, g_rst}, 1);
    @(negedge clk);
    chk("R5 pulse width", {31'h0, rst_req}, 0);
    rd_chk(3, "R4 trigger reads zero");
    acc(0, 1, 3, 32'h8);
    chk("R5 pulse with clear", {31'h0, g_rst}, 1);
    chk("R4 led cleared", {31'h0, led}, 0);
    chk("R4 remap cleared", {31'h0, remap}, 0);

    acc(0, 1, 12, 32'h0000F0F0); acc(0, 1, 13, 32'h00003000); rd_chk(12, "R6 flags");
    acc(0, 1, 14, 32'h81000001); acc(0, 1, 15, 32'h01000000); rd_chk(14, "R6 nvflags");
    acc(0, 1, 8, 32'hA5A55A5A); rd_chk(8, "R7 sdram");
    acc(0, 1, 9, 32'h00000777); rd_chk(9, "R7 init");

    acc(0, 1, 18, 32'h00000003); rd_chk(18, "R9 irq mask");
    acc(0, 1, 20, 32'hFFFFFFFF); rd_chk(20, "R10 soft set");
    rd_chk(16, "R9 irq status"); rd_chk(17, "R9 irq raw");
    chk("R10 cm_int irq", {31'h0, cm_int}, 1);
    acc(0, 1, 19, 32'h00000001); rd_chk(16, "R9 irq masked");
    chk("R10 cm_int masked", {31'h0, cm_int}, 0);
    acc(0, 1, 26, 32'h00000001); rd_chk(24, "R9 fiq status"); rd_chk(25, "R9 fiq raw");
    chk("R10 cm_int fiq", {31'h0, cm_int}, 1);
    acc(0, 1, 21, 32'hFFFFFFFE); rd_chk(20, "R10 clear bit0 only");
    chk("R10 cm_int held", {31'h0, cm_int}, 1);
    acc(0, 1, 21, 32'h00000001); rd_chk(24, "R10 soft clear");
    chk("R10 cm_int low", {31'h0, cm_int}, 0);
    acc(0, 1, 27, 32'hFFFFFFFF); rd_chk(26, "R9 fiq clear");

    for (int i = 32; i <= 35; i++) begin
      acc(0, 1, i, 32'hFFFFFFFF);
      chk("R1 voltage write err", {31'h0, g_err}, 0);
      rd_chk(i, "R1 voltage read");
    end

    for (int i = 0; i < NIDX; i++) begin
      if (!wr_valid(i)) begin
        acc(0, 1, i, 32'hFFFFFFFF);
        chk("R11 write err", {31'h0, g_err}, 1);
        @(negedge clk);
        chk("R11 err width", {31'h0, err}, 0);
      end
    end
    sweep();

    acc(1, 1, 8, 32'h13572468);
    chk("R12 old value", g_rd, 32'hA5A55A5A);
    rd_chk(8, "R12 new value");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule